// File: doc/BRIEF.md
# Snooped Frame-Buffer Write Window

This block sits beside a microprocessor bus with a 16-bit address and 8-bit data and watches every memory write. Any write whose address falls inside a movable 2K-byte window is copied into a local dual-port frame buffer, so the display side gets its own picture storage. The bus keeps reading from main memory. The block never returns data, never stalls the bus and never drives the data lines.

The window start is a 7-bit block number held in a register. Software loads it with an output-port write. Each block is 512 bytes, so the window can start on any 512-byte boundary. For every bus address the block subtracts the block number from the address's upper seven bits. The subtraction result must be free of borrow and smaller than four blocks. When it is, the two low bits of the result and the nine in-block address bits form an 11-bit buffer address. The buffer address, the write data and a one-cycle write strobe come out of registers one clock after the bus write is sampled.

Top module: `snoop_window_top`

## Requirements
- R1: While reset is held, and on the first cycles after it, `fb_we`, `fb_addr` and `fb_wdata` are all zero. The block number resets to 0, so after reset the window covers bus addresses 0x0000 to 0x07FF.
- R2: A clock edge with `bus_io_wr` high and `bus_io_port` equal to `BASE_PORT` (default 0x30) loads `bus_wdata[6:0]` as the new block number. An output-port write to any other port leaves the window unchanged.
- R3: A bus write is sampled on an edge where `bus_mem_wr` is high. It is a hit when `bus_addr[15:9]` minus the block number lies in 0 to 3. A hit raises `fb_we` on the following cycle.
- R4: On a hit, `fb_addr[10:9]` equals the low two bits of (`bus_addr[15:9]` − block number) and `fb_addr[8:0]` equals `bus_addr[8:0]`.
- R5: On a hit, `fb_wdata` equals the `bus_wdata` that was sampled with the write.
- R6: An address whose upper seven bits are below the block number never hits. This holds even when the window would wrap past 0xFFFF back to 0x0000.
- R7: An address four or more blocks above the block number never hits. The last hitting address is block number × 512 + 0x7FF.
- R8: A cycle with `bus_mem_wr` low never produces `fb_we`. This covers reads into the window.
- R9: `fb_we` is high for exactly one cycle per sampled write. It falls on the cycle after `bus_mem_wr` is removed.
- R10: A memory write sampled on the same edge as a block-number load is judged against the old block number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Live bus address |
| bus_wdata | input | 8 | Bus write data (memory and port writes) |
| bus_mem_wr | input | 1 | Memory write qualifier, one cycle per write |
| bus_io_wr | input | 1 | Output-port write qualifier |
| bus_io_port | input | 8 | Port number of an output-port write |
| fb_addr | output | 11 | Frame-buffer write address |
| fb_wdata | output | 8 | Frame-buffer write data |
| fb_we | output | 1 | Frame-buffer write strobe |

## Verification
Every frame-buffer result is due exactly one clock after the edge that samples `bus_mem_wr`. The bench drives stimulus on the falling edge and checks `fb_we`, `fb_addr` and `fb_wdata` just after the next rising edge. It then checks one cycle later that the strobe has dropped.

A block-number load takes effect at its own edge. The bench model therefore updates its copy only after that edge, which makes a write on the same edge use the old value. Random traffic is concentrated near the window edges and at the two ends of the address space.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int unsigned SNP_ADDR_W   = 16;
  localparam int unsigned SNP_DATA_W   = 8;
  localparam int unsigned SNP_PAGE_W   = 9;   // 512-byte blocks
  localparam int unsigned SNP_WIN_LG   = 2;   // 4 blocks = 2K window
  localparam int unsigned SNP_PORT_W   = 8;
  localparam logic [7:0]  SNP_BASE_PORT = 8'h30;
endpackage

// File: rtl/snoop_base_reg.sv
module snoop_base_reg #(
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned BASE_W    = 7,
  parameter logic [PORT_W-1:0] BASE_PORT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [BASE_W-1:0] io_data,
  output logic [BASE_W-1:0] base_q
);
  logic sel;
  assign sel = io_wr && (io_port == BASE_PORT);

  always_ff @(posedge clk) begin
    if (rst)      base_q <= '0;
    else if (sel) base_q <= io_data;
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && (io_port == BASE_PORT)) |=> $stable(base_q)); // R2
  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (io_wr && (io_port == BASE_PORT)) |=> base_q == $past(io_data)); // R2
endmodule

// File: rtl/snoop_window_calc.sv
module snoop_window_calc #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 9,
  parameter int unsigned WIN_LG = 2
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-PAGE_W-1:0] base,
  output logic                     hit,
  output logic [PAGE_W+WIN_LG-1:0] offset
);
  localparam int unsigned BLK_W = ADDR_W - PAGE_W;

  logic [BLK_W:0] diff;
  logic           borrow;
  logic           in_range;

  assign diff   = {1'b0, addr[ADDR_W-1:PAGE_W]} - {1'b0, base};
  assign borrow = diff[BLK_W];

  generate
    if (WIN_LG == 0) begin : g_one_block
      assign in_range = (diff[BLK_W-1:0] == '0);
      assign offset   = addr[PAGE_W-1:0];
    end else begin : g_multi_block
      assign in_range = (diff[BLK_W-1:WIN_LG] == '0);
      assign offset   = {diff[WIN_LG-1:0], addr[PAGE_W-1:0]};
    end
  endgenerate

  assign hit = in_range && !borrow;
endmodule

// File: rtl/snoop_write_out.sv
module snoop_write_out #(
  parameter int unsigned OFF_W  = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              hit,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] data,
  output logic              fb_we,
  output logic [OFF_W-1:0]  fb_addr,
  output logic [DATA_W-1:0] fb_wdata
);
  logic take;
  assign take = req && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
    end else begin
      fb_we <= take;
      if (take) begin
        fb_addr  <= offset;
        fb_wdata <= data;
      end
    end
  end

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> $past(req)); // R8
  AST_STROBE_DROPS: assert property (@(posedge clk) disable iff (rst)
    !req |=> !fb_we); // R9
endmodule

// File: rtl/snoop_window_top.sv
module snoop_window_top
  import snoop_pkg::*;
#(
  parameter int unsigned ADDR_W = SNP_ADDR_W,
  parameter int unsigned DATA_W = SNP_DATA_W,
  parameter int unsigned PAGE_W = SNP_PAGE_W,
  parameter int unsigned WIN_LG = SNP_WIN_LG,
  parameter int unsigned PORT_W = SNP_PORT_W,
  parameter logic [PORT_W-1:0] BASE_PORT = SNP_BASE_PORT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_mem_wr,
  input  logic                     bus_io_wr,
  input  logic [PORT_W-1:0]        bus_io_port,
  output logic [PAGE_W+WIN_LG-1:0] fb_addr,
  output logic [DATA_W-1:0]        fb_wdata,
  output logic                     fb_we
);
  localparam int unsigned BLK_W = ADDR_W - PAGE_W;
  localparam int unsigned OFF_W = PAGE_W + WIN_LG;

  logic [BLK_W-1:0] base_q;
  logic             hit;
  logic [OFF_W-1:0] offset;

  snoop_base_reg #(
    .PORT_W(PORT_W), .BASE_W(BLK_W), .BASE_PORT(BASE_PORT)
  ) u_base (
    .clk(clk), .rst(rst), .io_wr(bus_io_wr), .io_port(bus_io_port),
    .io_data(bus_wdata[BLK_W-1:0]), .base_q(base_q)
  );

  snoop_window_calc #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_LG(WIN_LG)
  ) u_calc (
    .addr(bus_addr), .base(base_q), .hit(hit), .offset(offset)
  );

  snoop_write_out #(
    .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_out (
    .clk(clk), .rst(rst), .req(bus_mem_wr), .hit(hit), .offset(offset),
    .data(bus_wdata), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fb_we && fb_addr == '0 && fb_wdata == '0)); // R1
  AST_NOT_BELOW: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> ({1'b0, $past(bus_addr[ADDR_W-1:PAGE_W])} >= {1'b0, $past(base_q)})); // R6
  AST_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> ({1'b0, $past(bus_addr[ADDR_W-1:PAGE_W])} <
               ({1'b0, $past(base_q)} + (BLK_W+1)'(1 << WIN_LG)))); // R7
  AST_LOW_ADDR: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> fb_addr[PAGE_W-1:0] == $past(bus_addr[PAGE_W-1:0])); // R4
  AST_DATA_COPY: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> fb_wdata == $past(bus_wdata)); // R5
endmodule

// File: tb/tb_snoop_window_top.sv
module tb_snoop_window_top;
  localparam int BASE_PORT = 'h30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_mem_wr = 1'b0;
  logic        bus_io_wr = 1'b0;
  logic [7:0]  bus_io_port = '0;
  logic [10:0] fb_addr;
  logic [7:0]  fb_wdata;
  logic        fb_we;

  always #5 clk = ~clk;

  snoop_window_top dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_mem_wr(bus_mem_wr), .bus_io_wr(bus_io_wr), .bus_io_port(bus_io_port),
    .fb_addr(fb_addr), .fb_wdata(fb_wdata), .fb_we(fb_we)
  );

  int total = 0;
  int bad = 0;
  int base_m = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit mdl_hit(int a, int b);
    int blk = a / 512;
    return (blk >= b) && (blk < b + 4);
  endfunction

  function automatic int mdl_off(int a, int b);
    return a - b * 512;
  endfunction

  task automatic set_base(int port, int val);
    @(negedge clk);
    bus_io_wr = 1'b1; bus_io_port = 8'(port); bus_wdata = 8'(val);
    @(negedge clk);
    bus_io_wr = 1'b0;
    if (port == BASE_PORT) base_m = val & 'h7F;
  endtask

  task automatic mem_cycle(int a, int d, bit wr, string req);
    bit exp;
    @(negedge clk);
    bus_mem_wr = wr; bus_addr = 16'(a); bus_wdata = 8'(d);
    @(posedge clk); #1;
    exp = wr && mdl_hit(a, base_m);
    chk(fb_we == exp, req, "fb_we", int'(fb_we), int'(exp));
    if (exp) begin
      chk(int'(fb_addr) == mdl_off(a, base_m), "R4", "fb_addr", int'(fb_addr), mdl_off(a, base_m));
      chk(int'(fb_wdata) == (d & 'hFF), "R5", "fb_wdata", int'(fb_wdata), d & 'hFF);
    end
    @(negedge clk);
    bus_mem_wr = 1'b0;
    @(posedge clk); #1;
    chk(fb_we == 1'b0, "R9", "fb_we after write", int'(fb_we), 0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(fb_we == 0, "R1", "fb_we in reset", int'(fb_we), 0);
    chk(fb_addr == 0, "R1", "fb_addr in reset", int'(fb_addr), 0);
    chk(fb_wdata == 0, "R1", "fb_wdata in reset", int'(fb_wdata), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(fb_we == 0, "R1", "fb_we after reset", int'(fb_we), 0);

    // R1: block number 0 after reset
    mem_cycle('h0000, 'hA5, 1, "R1");
    mem_cycle('h07FF, 'h3C, 1, "R7");
    mem_cycle('h0800, 'h11, 1, "R7");
    // R2: load block 0x10 (0x2000)
    set_base(BASE_PORT, 'h10);
    mem_cycle('h1FFF, 'h22, 1, "R6");
    mem_cycle('h2000, 'h33, 1, "R3");
    mem_cycle('h27FF, 'h44, 1, "R7");
    mem_cycle('h2800, 'h55, 1, "R7");
    // R2: other port ignored
    set_base('h31, 'h40);
    mem_cycle('h2123, 'h66, 1, "R2");
    mem_cycle('h8123, 'h67, 1, "R2");
    // R8: read into window
    mem_cycle('h2200, 'h77, 0, "R8");
    // R6: top of address space, no wrap
    set_base(BASE_PORT, 'h7E);
    mem_cycle('hFFFF, 'h88, 1, "R4");
    mem_cycle('hFC00, 'h89, 1, "R3");
    mem_cycle('h0000, 'h99, 1, "R6");
    mem_cycle('h01FF, 'h9A, 1, "R6");
    // R10: load and write on the same edge
    set_base(BASE_PORT, 'h10);
    @(negedge clk);
    bus_io_wr = 1'b1; bus_io_port = 8'(BASE_PORT); bus_wdata = 8'h20;
    bus_mem_wr = 1'b1; bus_addr = 16'h2100;
    @(posedge clk); #1;
    chk(fb_we == 1, "R10", "fb_we old base", int'(fb_we), 1);
    chk(fb_addr == 11'h100, "R10", "fb_addr old base", int'(fb_addr), 'h100);
    @(negedge clk);
    bus_io_wr = 1'b0; bus_mem_wr = 1'b0;
    base_m = 'h20;
    mem_cycle('h4000, 'hBB, 1, "R10");
    mem_cycle('h2100, 'hBC, 1, "R10");

    // random traffic
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 500; i++) begin
      int sel = $urandom_range(0, 9);
      if (sel == 0) begin
        set_base(($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255)) : BASE_PORT,
                 int'($urandom_range(0, 255)));
      end else begin
        int a;
        if (sel < 6) a = (base_m * 512 + int'($urandom_range(0, 3071)) - 512) & 'hFFFF;
        else a = int'($urandom_range(0, 'hFFFF));
        mem_cycle(a, int'($urandom_range(0, 255)), ($urandom_range(0, 4) != 0), "R3");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule